// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control sequencer for a 32-bit load/store processor whose datapath shares one ALU and one memory across several clock cycles. It receives the 6-bit opcode held in the instruction register and walks each instruction through its cycles. Every instruction starts with a fetch cycle and a decode cycle. A run of cycles specific to the instruction class follows, and then control returns to fetch.

In each state the sequencer drives the datapath selects and strobes as plain combinational decodes of the current state. These are the memory address source, the instruction register load, the unconditional and zero-qualified PC loads, both ALU operand selects, the ALU mode, the PC source, the register destination, the write-back source, the register write and the memory read and write strobes. A parameter chooses binary or one-hot storage for the state register, and the opcode values are parameters.

Top module: `mc_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the sequencer in the fetch state, from any state. The fetch outputs are visible in the cycle after that edge.
- R2: In fetch, ir_load=1, pc_load=1, alu_b_sel=01 (constant four) and alu_mode=00 (add). mem_sel_data=0, alu_a_sel=0 and pc_src=00 apply, and every other output is 0. The next state is always decode.
- R3: In decode, alu_b_sel=11 (shifted sign-extended offset), alu_a_sel=0 and alu_mode=00. Every other output is 0.
- R4: Opcode 000000 (register arithmetic) continues after decode with an execute cycle (alu_a_sel=1, alu_b_sel=00, alu_mode=10 meaning funct-controlled). A completion cycle follows with dst_sel_rd=1, wb_from_mem=0 and rf_write=1. The instruction takes 4 cycles.
- R5: Opcode 100011 (load) continues after decode with an address cycle (alu_a_sel=1, alu_b_sel=10, alu_mode=00). It then has a memory cycle (mem_sel_data=1, mem_rd=1) and a completion cycle (wb_from_mem=1, dst_sel_rd=0, rf_write=1). The instruction takes 5 cycles.
- R6: Opcode 101011 (store) uses the same address cycle as load, then a memory cycle with mem_sel_data=1 and mem_wr=1. It takes 4 cycles and never asserts rf_write.
- R7: Opcode 000100 (branch if equal) continues after decode with one cycle of alu_a_sel=1, alu_b_sel=00, alu_mode=01 (subtract), pc_src=01 (held ALU result) and pc_load_if_zero=1. pc_load stays 0 in that cycle. The instruction takes 3 cycles.
- R8: Opcode 000010 (jump) continues after decode with one cycle of pc_src=10 and pc_load=1. The instruction takes 3 cycles.
- R9: Any other opcode returns to fetch straight after decode. No register write, memory strobe or PC load is driven for that opcode beyond its fetch cycle.
- R10: In every state, outputs that are not named for that state are 0. mem_rd and mem_wr are never both 1, and pc_load and pc_load_if_zero are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_sel_data | output | 1 | Memory address from ALU result register (1) or PC (0) |
| ir_load | output | 1 | Instruction register load |
| pc_load | output | 1 | Unconditional PC load |
| pc_load_if_zero | output | 1 | PC load qualified by the ALU zero flag |
| alu_a_sel | output | 1 | ALU operand A: A register (1) or PC (0) |
| alu_b_sel | output | 2 | ALU operand B: 00 B register, 01 four, 10 offset, 11 offset shifted by 2 |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 from funct field |
| pc_src | output | 2 | 00 ALU output, 01 ALU result register, 10 jump target |
| dst_sel_rd | output | 1 | Destination register from rd (1) or rt (0) |
| wb_from_mem | output | 1 | Write-back data from memory data register (1) or ALU result register (0) |
| rf_write | output | 1 | Register file write |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |

## Verification
Two functions share the fetch cycle: capturing the instruction and advancing the PC by four. Each fetch is therefore judged on the whole output word, so ir_load, pc_load, the constant-four operand and the add mode must all appear together with no other strobe. A second overlap sits between the last cycle of one instruction and the decision for the next. The bench changes the opcode during the fetch cycle that directly follows a completion cycle, runs instructions back to back, and checks that the path taken after decode follows the new opcode. A reset is also applied in the middle of a load, in its memory cycle, to confirm that reset takes precedence over the pending completion cycle.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

   typedef enum logic [3:0] {
      ST_FETCH   = 4'd0,
      ST_DECODE  = 4'd1,
      ST_ADDR    = 4'd2,
      ST_RD_MEM  = 4'd3,
      ST_WR_MEM  = 4'd4,
      ST_LD_DONE = 4'd5,
      ST_EXEC    = 4'd6,
      ST_R_DONE  = 4'd7,
      ST_BRANCH  = 4'd8,
      ST_JUMP    = 4'd9
   } mcf_state_e;

   localparam int unsigned NUM_STATES = 10;

   typedef enum logic [2:0] {
      CL_NONE   = 3'd0,
      CL_ALU    = 3'd1,
      CL_LOAD   = 3'd2,
      CL_STORE  = 3'd3,
      CL_BRANCH = 3'd4,
      CL_JUMP   = 3'd5
   } op_class_e;

   localparam logic [1:0] B_REG  = 2'b00;
   localparam logic [1:0] B_FOUR = 2'b01;
   localparam logic [1:0] B_IMM  = 2'b10;
   localparam logic [1:0] B_BOFS = 2'b11;

   localparam logic [1:0] M_ADD   = 2'b00;
   localparam logic [1:0] M_SUB   = 2'b01;
   localparam logic [1:0] M_FUNCT = 2'b10;

   localparam logic [1:0] PS_ALU  = 2'b00;
   localparam logic [1:0] PS_HELD = 2'b01;
   localparam logic [1:0] PS_JUMP = 2'b10;

   typedef struct packed {
      logic       data_addr;
      logic       ir_load;
      logic       pc_load;
      logic       pc_load_zero;
      logic       a_from_reg;
      logic [1:0] b_sel;
      logic [1:0] alu_mode;
      logic [1:0] pc_src;
      logic       dst_rd;
      logic       wb_mem;
      logic       rf_we;
      logic       mem_re;
      logic       mem_we;
   } ctrl_t;

   localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mcf_op_class.sv
module mcf_op_class
   import mcf_pkg::*;
#(
   parameter int unsigned OP_W      = 6,
   parameter logic [OP_W-1:0] OP_ALU    = 6'b000000,
   parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
   parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
   parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
   parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
   input  logic [OP_W-1:0] op,
   output op_class_e       cls
);

   localparam int unsigned NCL = 5;
   localparam logic [NCL-1:0][OP_W-1:0] CODES =
      {OP_JUMP, OP_BRANCH, OP_STORE, OP_LOAD, OP_ALU};

   if (OP_W < 3) begin : g_bad_width
      $error("mcf_op_class: OP_W must be at least 3");
   end

   for (genvar i = 0; i < NCL; i++) begin : g_distinct_i
      for (genvar j = i + 1; j < NCL; j++) begin : g_distinct_j
         if (CODES[i] == CODES[j]) begin : g_clash
            $error("mcf_op_class: two instruction classes share one opcode");
         end
      end
   end

   logic [NCL-1:0] hit;

   for (genvar k = 0; k < NCL; k++) begin : g_match
      assign hit[k] = (op == CODES[k]);
   end

   always_comb begin
      case (hit)
         5'b00001: cls = CL_ALU;
         5'b00010: cls = CL_LOAD;
         5'b00100: cls = CL_STORE;
         5'b01000: cls = CL_BRANCH;
         5'b10000: cls = CL_JUMP;
         default:  cls = CL_NONE;
      endcase
   end

endmodule

// File: rtl/mcf_next.sv
module mcf_next
   import mcf_pkg::*;
(
   input  mcf_state_e cur,
   input  op_class_e  cls,
   output mcf_state_e nxt
);

   always_comb begin
      nxt = ST_FETCH;
      case (cur)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            case (cls)
               CL_ALU:    nxt = ST_EXEC;
               CL_LOAD,
               CL_STORE:  nxt = ST_ADDR;
               CL_BRANCH: nxt = ST_BRANCH;
               CL_JUMP:   nxt = ST_JUMP;
               default:   nxt = ST_FETCH;
            endcase
         end
         ST_ADDR: begin
            if (cls == CL_LOAD)       nxt = ST_RD_MEM;
            else if (cls == CL_STORE) nxt = ST_WR_MEM;
            else                      nxt = ST_FETCH;
         end
         ST_RD_MEM: nxt = ST_LD_DONE;
         ST_EXEC:   nxt = ST_R_DONE;
         default:   nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mcf_state_reg.sv
module mcf_state_reg
   import mcf_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  mcf_state_e nxt,
   output mcf_state_e cur
);

   localparam int unsigned SW = $bits(mcf_state_e);

   if (ONE_HOT) begin : g_onehot
      logic [NUM_STATES-1:0] oh_q;

      always_ff @(posedge clk) begin
         if (rst) oh_q <= NUM_STATES'(1);
         else     oh_q <= NUM_STATES'(1) << nxt;
      end

      always_comb begin
         logic [SW-1:0] idx;
         idx = '0;
         for (int s = 0; s < NUM_STATES; s++) begin
            if (oh_q[s]) idx = idx | SW'(s);
         end
         cur = mcf_state_e'(idx);
      end

      assert_onehot_state_R10: assert property (@(posedge clk) disable iff (rst)
         $onehot(oh_q));
   end else begin : g_binary
      mcf_state_e st_q;

      always_ff @(posedge clk) begin
         if (rst) st_q <= ST_FETCH;
         else     st_q <= nxt;
      end

      assign cur = st_q;
   end

endmodule

// File: rtl/mcf_out_dec.sv
module mcf_out_dec
   import mcf_pkg::*;
(
   input  mcf_state_e cur,
   output ctrl_t      ctl
);

   always_comb begin
      ctl = CTRL_IDLE;
      case (cur)
         ST_FETCH: begin
            ctl.ir_load  = 1'b1;
            ctl.pc_load  = 1'b1;
            ctl.b_sel    = B_FOUR;
            ctl.alu_mode = M_ADD;
            ctl.pc_src   = PS_ALU;
         end
         ST_DECODE: begin
            ctl.b_sel    = B_BOFS;
            ctl.alu_mode = M_ADD;
         end
         ST_ADDR: begin
            ctl.a_from_reg = 1'b1;
            ctl.b_sel      = B_IMM;
            ctl.alu_mode   = M_ADD;
         end
         ST_RD_MEM: begin
            ctl.data_addr = 1'b1;
            ctl.mem_re    = 1'b1;
         end
         ST_WR_MEM: begin
            ctl.data_addr = 1'b1;
            ctl.mem_we    = 1'b1;
         end
         ST_LD_DONE: begin
            ctl.wb_mem = 1'b1;
            ctl.dst_rd = 1'b0;
            ctl.rf_we  = 1'b1;
         end
         ST_EXEC: begin
            ctl.a_from_reg = 1'b1;
            ctl.b_sel      = B_REG;
            ctl.alu_mode   = M_FUNCT;
         end
         ST_R_DONE: begin
            ctl.dst_rd = 1'b1;
            ctl.wb_mem = 1'b0;
            ctl.rf_we  = 1'b1;
         end
         ST_BRANCH: begin
            ctl.a_from_reg   = 1'b1;
            ctl.b_sel        = B_REG;
            ctl.alu_mode     = M_SUB;
            ctl.pc_src       = PS_HELD;
            ctl.pc_load_zero = 1'b1;
         end
         ST_JUMP: begin
            ctl.pc_src  = PS_JUMP;
            ctl.pc_load = 1'b1;
         end
         default: ctl = CTRL_IDLE;
      endcase
   end

endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
   import mcf_pkg::*;
#(
   parameter int unsigned OP_W      = 6,
   parameter logic [OP_W-1:0] OP_ALU    = 6'b000000,
   parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
   parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
   parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
   parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010,
   parameter bit              ONE_HOT   = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] opcode,
   output logic            mem_sel_data,
   output logic            ir_load,
   output logic            pc_load,
   output logic            pc_load_if_zero,
   output logic            alu_a_sel,
   output logic [1:0]      alu_b_sel,
   output logic [1:0]      alu_mode,
   output logic [1:0]      pc_src,
   output logic            dst_sel_rd,
   output logic            wb_from_mem,
   output logic            rf_write,
   output logic            mem_rd,
   output logic            mem_wr
);

   op_class_e  cls;
   mcf_state_e state;
   mcf_state_e state_nxt;
   ctrl_t      ctl;

   mcf_op_class #(
      .OP_W      (OP_W),
      .OP_ALU    (OP_ALU),
      .OP_LOAD   (OP_LOAD),
      .OP_STORE  (OP_STORE),
      .OP_BRANCH (OP_BRANCH),
      .OP_JUMP   (OP_JUMP)
   ) u_class (
      .op  (opcode),
      .cls (cls)
   );

   mcf_next u_next (
      .cur (state),
      .cls (cls),
      .nxt (state_nxt)
   );

   mcf_state_reg #(
      .ONE_HOT (ONE_HOT)
   ) u_state (
      .clk (clk),
      .rst (rst),
      .nxt (state_nxt),
      .cur (state)
   );

   mcf_out_dec u_dec (
      .cur (state),
      .ctl (ctl)
   );

   assign mem_sel_data    = ctl.data_addr;
   assign ir_load         = ctl.ir_load;
   assign pc_load         = ctl.pc_load;
   assign pc_load_if_zero = ctl.pc_load_zero;
   assign alu_a_sel       = ctl.a_from_reg;
   assign alu_b_sel       = ctl.b_sel;
   assign alu_mode        = ctl.alu_mode;
   assign pc_src          = ctl.pc_src;
   assign dst_sel_rd      = ctl.dst_rd;
   assign wb_from_mem     = ctl.wb_mem;
   assign rf_write        = ctl.rf_we;
   assign mem_rd          = ctl.mem_re;
   assign mem_wr          = ctl.mem_we;

   assert_fetch_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (ir_load && pc_load));

   assert_decode_follows_fetch_R3: assert property (@(posedge clk) disable iff (rst)
      ir_load |=> (alu_b_sel == B_BOFS && !ir_load));

   assert_alu_path_R4: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DECODE && cls == CL_ALU) |=> (alu_mode == M_FUNCT));

   assert_load_writeback_R5: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> (rf_write && wb_from_mem && !dst_sel_rd));

   assert_store_returns_R6: assert property (@(posedge clk) disable iff (rst)
      mem_wr |=> (ir_load && !rf_write));

   assert_branch_cond_only_R7: assert property (@(posedge clk) disable iff (rst)
      pc_load_if_zero |=> ir_load);

   assert_jump_returns_R8: assert property (@(posedge clk) disable iff (rst)
      (pc_load && pc_src == PS_JUMP) |=> ir_load);

   assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DECODE && cls == CL_NONE) |=> ir_load);

   assert_mem_excl_R10: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   assert_pc_excl_R10: assert property (@(posedge clk) disable iff (rst)
      !(pc_load && pc_load_if_zero));

endmodule

// File: tb/mc_sequencer_test.sv
module mc_sequencer_test;

   localparam time CLK_P = 10ns;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = 6'b000000;

   logic       mem_sel_data, ir_load, pc_load, pc_load_if_zero, alu_a_sel;
   logic [1:0] alu_b_sel, alu_mode, pc_src;
   logic       dst_sel_rd, wb_from_mem, rf_write, mem_rd, mem_wr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   mc_sequencer uut (
      .clk             (clk),
      .rst             (rst),
      .opcode          (opcode),
      .mem_sel_data    (mem_sel_data),
      .ir_load         (ir_load),
      .pc_load         (pc_load),
      .pc_load_if_zero (pc_load_if_zero),
      .alu_a_sel       (alu_a_sel),
      .alu_b_sel       (alu_b_sel),
      .alu_mode        (alu_mode),
      .pc_src          (pc_src),
      .dst_sel_rd      (dst_sel_rd),
      .wb_from_mem     (wb_from_mem),
      .rf_write        (rf_write),
      .mem_rd          (mem_rd),
      .mem_wr          (mem_wr)
   );

   // word order: sel_data ir pc pcz a b[2] mode[2] src[2] rd wbm rfw mrd mwr
   function automatic logic [15:0] cv(input logic sd, input logic ir, input logic pc,
                                      input logic pz, input logic a, input logic [1:0] b,
                                      input logic [1:0] m, input logic [1:0] s,
                                      input logic rd, input logic wm, input logic rw,
                                      input logic mr, input logic mw);
      return {sd, ir, pc, pz, a, b, m, s, rd, wm, rw, mr, mw};
   endfunction

   wire [15:0] outv = {mem_sel_data, ir_load, pc_load, pc_load_if_zero, alu_a_sel,
                       alu_b_sel, alu_mode, pc_src, dst_sel_rd, wb_from_mem,
                       rf_write, mem_rd, mem_wr};

   localparam logic [15:0] P_FETCH = {1'b0,1'b1,1'b1,1'b0,1'b0,2'b01,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};

   logic [15:0] p_dec, p_exec, p_rdone, p_addr, p_rdm, p_wrm, p_lddone, p_br, p_jmp;

   initial begin
      p_dec    = cv(0,0,0,0,0,2'b11,2'b00,2'b00,0,0,0,0,0);
      p_exec   = cv(0,0,0,0,1,2'b00,2'b10,2'b00,0,0,0,0,0);
      p_rdone  = cv(0,0,0,0,0,2'b00,2'b00,2'b00,1,0,1,0,0);
      p_addr   = cv(0,0,0,0,1,2'b10,2'b00,2'b00,0,0,0,0,0);
      p_rdm    = cv(1,0,0,0,0,2'b00,2'b00,2'b00,0,0,0,1,0);
      p_wrm    = cv(1,0,0,0,0,2'b00,2'b00,2'b00,0,0,0,0,1);
      p_lddone = cv(0,0,0,0,0,2'b00,2'b00,2'b00,0,1,1,0,0);
      p_br     = cv(0,0,0,1,1,2'b00,2'b01,2'b01,0,0,0,0,0);
      p_jmp    = cv(0,0,1,0,0,2'b00,2'b00,2'b10,0,0,0,0,0);
   end

   task automatic chk(input logic [15:0] exp, input string tag);
      n_checks++;
      if (outv !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, outv, exp);
      end
   endtask

   task automatic adv;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic test_reset;
      rst = 1'b1;
      adv; adv;
      chk(P_FETCH, "R1 fetch during reset");
      rst = 1'b0;
      chk(P_FETCH, "R1 fetch after release");
   endtask

   task automatic test_rtype;
      opcode = 6'b000000;
      chk(P_FETCH, "R2 fetch word");
      adv; chk(p_dec,   "R3 decode word");
      adv; chk(p_exec,  "R4 execute");
      adv; chk(p_rdone, "R4 completion");
      adv; chk(P_FETCH, "R4 back to fetch after 4 cycles");
   endtask

   task automatic test_load;
      opcode = 6'b100011;
      adv; chk(p_dec,    "R3 decode for load");
      adv; chk(p_addr,   "R5 address compute");
      adv; chk(p_rdm,    "R5 memory read");
      adv; chk(p_lddone, "R5 load completion");
      adv; chk(P_FETCH,  "R5 back to fetch after 5 cycles");
   endtask

   task automatic test_store;
      opcode = 6'b101011;
      adv; chk(p_dec,   "R3 decode for store");
      adv; chk(p_addr,  "R6 address compute");
      adv; chk(p_wrm,   "R6 memory write");
      adv; chk(P_FETCH, "R6 back to fetch after 4 cycles");
   endtask

   task automatic test_branch;
      opcode = 6'b000100;
      adv; chk(p_dec,   "R3 decode for branch");
      adv; chk(p_br,    "R7 branch compare");
      adv; chk(P_FETCH, "R7 back to fetch after 3 cycles");
   endtask

   task automatic test_jump;
      opcode = 6'b000010;
      adv; chk(p_dec,   "R3 decode for jump");
      adv; chk(p_jmp,   "R8 jump");
      adv; chk(P_FETCH, "R8 back to fetch after 3 cycles");
   endtask

   task automatic test_unknown(input logic [5:0] op);
      opcode = op;
      adv; chk(p_dec,   "R9 decode for unknown opcode");
      adv; chk(P_FETCH, "R9 unknown opcode returns to fetch");
   endtask

   task automatic test_reset_midway;
      opcode = 6'b100011;
      adv; adv; adv;
      chk(p_rdm, "R1 load reached memory cycle");
      rst = 1'b1;
      adv;
      chk(P_FETCH, "R1 reset from memory cycle");
      rst = 1'b0;
      adv;
      opcode = 6'b000010;
      chk(p_dec, "R1 decode after reset release");
      adv; chk(p_jmp,   "R8 jump after reset");
      adv; chk(P_FETCH, "R8 fetch after reset jump");
   endtask

   initial begin
      @(negedge clk);
      test_reset();
      test_rtype();
      test_load();
      test_store();
      test_branch();
      test_jump();
      test_unknown(6'b111111);
      test_unknown(6'b000001);
      test_unknown(6'b100010);
      test_rtype();
      test_branch();
      test_reset_midway();
      test_store();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule